// File: doc/BRIEF.md
# Width-Halving FIFO with Reread

This block is a single-direction first-in first-out buffer. A wide producer writes 18-bit words. A narrow consumer reads them back as 9-bit lanes, two lanes per stored word. Each lane carries eight data bits in bits 7:0 and one parity bit in bit 8. The lower half of a word is sent first. The upper half waits in a holding register, and a phase bit records that it is pending.

A reread pointer marks the start of the word that is currently being drained. A reread strobe moves the read position back to that mark, so the word can be sent again from its lower half. For every lane it sends, the block works out a fresh parity bit of the selected type and puts it on the output. It also compares that bit with the parity bit that was stored. When they differ, it sets an error flag that stays set. A pointer-reset strobe empties the buffer without touching the error flag.

Top module: `bmf_reread_fifo`

## Requirements
- R1: After `rst`, `empty`=1, `full`=0, `rd_lane`=0 and `par_err`=0.
- R2: A write with `wr_en`=1 stores `wr_word` when `full`=0. When `full`=1 the write is ignored: the stored words and their order do not change.
- R3: Each stored word leaves as two lanes: bits 8:0 first, then bits 17:9. The lane for a read strobe accepted at a rising edge appears on `rd_lane` right after that edge.
- R4: Bit 8 of every lane on `rd_lane` is regenerated from bits 7:0. With `odd_par`=0 it is the XOR of bits 7:0 (even parity). With `odd_par`=1 it is the inverse of that XOR (odd parity).
- R5: If the stored bit 8 of a lane being read differs from the regenerated bit, `par_err` becomes 1. It stays 1 until `rst`. `ptr_rst` does not clear it.
- R6: `empty`=1 only when no stored word remains and no upper half is pending. A read strobe while `empty`=1 is ignored, and `rd_lane` keeps its value.
- R7: A `reread` strobe returns the read position to the reread pointer and drops a pending upper half. The next read gives the lower half of the same word. The reread pointer moves past a word once that word's upper half has been read.
- R8: Occupancy is counted from the reread pointer. A word whose lower half has been read still takes space. `full`=1 when DEPTH words are held on that count.
- R9: `ptr_rst` sets the write, read and reread pointers to 0 and drops any pending half. Afterwards `empty`=1, `full`=0, and the next word written is the next word read.
- R10: Priority order is `rst`, then `ptr_rst`, then `reread`, then read. A read in the same cycle as `reread` or `ptr_rst` is ignored. A write in the same cycle as `ptr_rst` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_rst | input | 1 | Pointer reset strobe |
| odd_par | input | 1 | Parity type on the narrow side: 1 odd, 0 even |
| wr_en | input | 1 | Wide write strobe |
| wr_word | input | 2*LANE_W | Word to store, upper lane in the high bits |
| full | output | 1 | No room for another word |
| rd_en | input | 1 | Narrow read strobe |
| reread | input | 1 | Restart the word being drained |
| rd_lane | output | LANE_W | Registered narrow output lane |
| empty | output | 1 | Nothing left to read |
| par_err | output | 1 | Sticky parity mismatch flag |

## Verification
`rd_lane` and `par_err` are registered. Each one changes at the rising edge that accepts the read strobe, which is one cycle after the strobe is driven. `full` and `empty` are decoded from the pointer registers, so they reflect a write, read, reread or pointer reset as of that same edge. The bench drives its inputs just after a rising edge. A monitor notes each read the driver announced at the capturing edge, then pops the expected lane from the scoreboard and compares it half a period later, at the falling edge. Flag checks are sampled at that same falling edge.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

  // Phase of the word being drained on the narrow side.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  localparam int LANES_PER_WORD = 2;

endpackage

// File: rtl/bmf_ram.sv
module bmf_ram #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 18
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WORD_W-1:0]        rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read: the word under the read pointer is ready in the same cycle.
  assign rdata = mem[raddr];

endmodule

// File: rtl/bmf_ptrs.sv
module bmf_ptrs
  import bmf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ptr_rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     reread,
  output logic                     full,
  output logic                     empty,
  output logic                     wr_ok,
  output logic                     take_lo,
  output logic                     take_hi,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic [$clog2(DEPTH)-1:0] raddr
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] WRAP    = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] wptr, rptr, rrptr;
  half_e         phase;
  logic          rd_ok;
  logic [PW-1:0] occ;

  assign empty   = (rptr == wptr) && (phase == HALF_LO);
  assign full    = (wptr ^ rrptr) == WRAP;
  assign wr_ok   = wr_en && !full && !ptr_rst;
  assign rd_ok   = rd_en && !empty && !ptr_rst && !reread;
  assign take_lo = rd_ok && (phase == HALF_LO);
  assign take_hi = rd_ok && (phase == HALF_HI);
  assign waddr   = wptr[AW-1:0];
  assign raddr   = rptr[AW-1:0];
  assign occ     = wptr - rrptr;

  always_ff @(posedge clk) begin
    if (rst || ptr_rst) begin
      wptr  <= '0;
      rptr  <= '0;
      rrptr <= '0;
      phase <= HALF_LO;
    end else begin
      if (wr_ok) wptr <= wptr + PW'(1);
      if (reread) begin
        rptr  <= rrptr;
        phase <= HALF_LO;
      end else if (take_lo) begin
        rptr  <= rptr + PW'(1);
        phase <= HALF_HI;
      end else if (take_hi) begin
        rrptr <= rptr;
        phase <= HALF_LO;
      end
    end
  end

  // R2: a full buffer leaves the write pointer alone
  a_r2_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
    full && !ptr_rst |=> wptr == $past(wptr));

  // R6: an empty buffer leaves the read position alone
  a_r6_empty_blocks_read: assert property (@(posedge clk) disable iff (rst)
    empty && !ptr_rst && !reread |=> rptr == $past(rptr) && phase == HALF_LO);

  // R7: reread lands on the reread pointer with no pending half
  a_r7_reread_restores: assert property (@(posedge clk) disable iff (rst)
    reread && !ptr_rst |=> rptr == $past(rrptr) && phase == HALF_LO);

  // R7: the read position is never more than one word past the reread pointer
  a_r7_reread_trails: assert property (@(posedge clk) disable iff (rst)
    (rptr - rrptr) <= PW'(1));

  // R8: occupancy measured from the reread pointer never exceeds DEPTH
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= DEPTH_P);

  // R9: pointer reset zeroes every pointer
  a_r9_ptr_reset: assert property (@(posedge clk) disable iff (rst)
    ptr_rst |=> wptr == '0 && rptr == '0 && rrptr == '0 && phase == HALF_LO);

endmodule

// File: rtl/bmf_lane.sv
module bmf_lane #(
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  odd_par,
  input  logic                  take_lo,
  input  logic                  take_hi,
  input  logic [2*LANE_W-1:0]   word,
  output logic [LANE_W-1:0]     rd_lane,
  output logic                  par_err
);

  localparam int DW = LANE_W - 1;

  logic [LANE_W-1:0] hold;
  logic [LANE_W-1:0] lane_in;
  logic              pbit;
  logic              mism;
  logic              take;

  assign take = take_lo || take_hi;

  always_comb begin
    lane_in = take_lo ? word[LANE_W-1:0] : hold;
    pbit    = (^lane_in[DW-1:0]) ^ odd_par;
    mism    = lane_in[DW] != pbit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      rd_lane <= '0;
      par_err <= 1'b0;
    end else begin
      if (take_lo) hold <= word[2*LANE_W-1:LANE_W];
      if (take) begin
        rd_lane <= {pbit, lane_in[DW-1:0]};
        if (mism) par_err <= 1'b1;
      end
    end
  end

  // R4: every emitted lane has the selected overall parity
  a_r4_lane_parity: assert property (@(posedge clk) disable iff (rst)
    take |=> (^rd_lane) == $past(odd_par));

  // R5: the error flag only falls through reset
  a_r5_sticky_error: assert property (@(posedge clk) disable iff (rst)
    par_err |=> par_err);

  // R6: no accepted read, no change on the lane output
  a_r6_lane_holds: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(rd_lane));

endmodule

// File: rtl/bmf_reread_fifo.sv
module bmf_reread_fifo #(
  parameter int DEPTH  = 16,
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ptr_rst,
  input  logic                  odd_par,
  input  logic                  wr_en,
  input  logic [2*LANE_W-1:0]   wr_word,
  output logic                  full,
  input  logic                  rd_en,
  input  logic                  reread,
  output logic [LANE_W-1:0]     rd_lane,
  output logic                  empty,
  output logic                  par_err
);

  localparam int WORD_W = bmf_pkg::LANES_PER_WORD * LANE_W;
  localparam int AW     = $clog2(DEPTH);

  logic          wr_ok, take_lo, take_hi;
  logic [AW-1:0] waddr, raddr;
  logic [WORD_W-1:0] rword;

  bmf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .ptr_rst (ptr_rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .reread  (reread),
    .full    (full),
    .empty   (empty),
    .wr_ok   (wr_ok),
    .take_lo (take_lo),
    .take_hi (take_hi),
    .waddr   (waddr),
    .raddr   (raddr)
  );

  bmf_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (waddr),
    .wdata (wr_word),
    .raddr (raddr),
    .rdata (rword)
  );

  bmf_lane #(.LANE_W(LANE_W)) u_lane (
    .clk     (clk),
    .rst     (rst),
    .odd_par (odd_par),
    .take_lo (take_lo),
    .take_hi (take_hi),
    .word    (rword),
    .rd_lane (rd_lane),
    .par_err (par_err)
  );

  // R1: empty and full never hold together
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R9: after a pointer reset the buffer reads as empty
  a_r9_empty_after_ptr_rst: assert property (@(posedge clk) disable iff (rst)
    ptr_rst |=> empty && !full);

endmodule

// File: tb/bmf_reread_fifo_tb.sv
module bmf_reread_fifo_tb;

  localparam int DEPTH  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = 2 * LANE_W;

  logic clk = 1'b0;
  logic rst, ptr_rst, odd_par, wr_en, rd_en, reread;
  logic [WORD_W-1:0] wr_word;
  logic full, empty, par_err;
  logic [LANE_W-1:0] rd_lane;

  always #4 clk = ~clk;

  bmf_reread_fifo #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst(rst), .ptr_rst(ptr_rst), .odd_par(odd_par),
    .wr_en(wr_en), .wr_word(wr_word), .full(full),
    .rd_en(rd_en), .reread(reread), .rd_lane(rd_lane),
    .empty(empty), .par_err(par_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [WORD_W-1:0] wq[$];
  logic [LANE_W-1:0] exp_q[$];
  string             tag_q[$];
  bit                mhalf = 0;
  bit                mperr = 0;
  logic [LANE_W-1:0] last_lane = '0;
  bit                mon_due = 0;

  function automatic logic [WORD_W-1:0] mk(input logic [7:0] lo, input logic [7:0] hi, input logic odd);
    return {(^hi) ^ odd, hi, (^lo) ^ odd, lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr1(input logic [WORD_W-1:0] w);
    if (wq.size() < DEPTH) wq.push_back(w);
    wr_word = w;
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  // Driver: derives the expected lane from the scoreboard and issues one read.
  task automatic rd1(input string req);
    logic [WORD_W-1:0] w;
    logic [LANE_W-1:0] src;
    logic p;
    w   = wq[0];
    src = mhalf ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
    p   = (^src[7:0]) ^ odd_par;
    if (src[8] != p) mperr = 1;
    last_lane = {p, src[7:0]};
    exp_q.push_back(last_lane);
    tag_q.push_back(req);
    if (mhalf) void'(wq.pop_front());
    mhalf = !mhalf;
    rd_en = 1'b1;
    mon_due = 1;
    tick();
    rd_en = 1'b0;
    mon_due = 0;
  endtask

  task automatic do_reread();
    reread = 1'b1;
    mhalf = 0;
    tick();
    reread = 1'b0;
  endtask

  // Monitor: compares each announced read half a period after its capture edge.
  initial begin
    forever begin
      @(posedge clk);
      if (mon_due) begin
        #4;
        if (exp_q.size() == 0) begin
          chk("R3 unexpected lane", 32'(rd_lane), 32'hFFFF);
        end else begin
          logic [LANE_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, 32'(rd_lane), 32'(e));
        end
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst = 1; ptr_rst = 0; odd_par = 0; wr_en = 0; rd_en = 0; reread = 0; wr_word = '0;
    repeat (3) tick();
    rst = 0;
    @(negedge clk);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 rd_lane", 32'(rd_lane), 0);
    chk("R1 par_err", 32'(par_err), 0);

    // R3 / R4: ordering of halves and even parity
    tick();
    wr1(mk(8'h12, 8'h34, 0));
    wr1(mk(8'hA5, 8'h0F, 0));
    wr1(mk(8'h00, 8'hFF, 0));
    for (int i = 0; i < 6; i++) rd1("R3 R4 even lanes");
    @(negedge clk);
    chk("R6 empty after drain", 32'(empty), 1);

    // R6: read when empty is ignored
    tick();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    @(negedge clk);
    chk("R6 lane held", 32'(rd_lane), 32'(last_lane));
    chk("R6 still empty", 32'(empty), 1);

    // R2 / R8: fill, blocked write, occupancy from reread pointer
    tick();
    for (int i = 0; i < DEPTH; i++) wr1(mk(8'(8'h40 + i), 8'(8'hC0 + i), 0));
    @(negedge clk);
    chk("R8 full", 32'(full), 1);
    tick();
    wr1(mk(8'hEE, 8'hDD, 0));
    rd1("R2 first after blocked write");
    @(negedge clk);
    chk("R8 full after lower half", 32'(full), 1);
    tick();
    rd1("R3 upper half");
    @(negedge clk);
    chk("R8 room after whole word", 32'(full), 0);
    tick();
    for (int i = 0; i < 2 * (DEPTH - 1); i++) rd1("R2 order kept");
    @(negedge clk);
    chk("R2 empty after full drain", 32'(empty), 1);

    // R7: reread
    tick();
    wr1(mk(8'h11, 8'h22, 0));
    wr1(mk(8'h33, 8'h44, 0));
    rd1("R7 lower half");
    do_reread();
    rd1("R7 lower half again");
    rd1("R7 upper half");
    do_reread();
    rd1("R7 pointer moved on");
    rd1("R7 last upper");

    // R10: read with reread in the same cycle is ignored
    wr1(mk(8'h55, 8'h66, 0));
    rd1("R10 setup lower");
    rd_en = 1'b1; reread = 1'b1; mhalf = 0;
    tick();
    rd_en = 1'b0; reread = 1'b0;
    @(negedge clk);
    chk("R10 read dropped with reread", 32'(rd_lane), 32'(last_lane));
    tick();
    rd1("R10 lower after reread");
    rd1("R10 upper after reread");

    // R4: odd parity
    odd_par = 1;
    wr1(mk(8'h07, 8'h80, 1));
    wr1(mk(8'hFF, 8'h00, 1));
    for (int i = 0; i < 4; i++) rd1("R4 odd lanes");
    @(negedge clk);
    chk("R5 no error on good parity", 32'(par_err), 32'(mperr));

    // R5: bad stored parity
    tick();
    odd_par = 0;
    wr1(mk(8'h3C, 8'h5A, 0) ^ 18'h00100);
    wr1(mk(8'h01, 8'h02, 0));
    for (int i = 0; i < 4; i++) rd1("R5 lanes with bad bit");
    @(negedge clk);
    chk("R5 error raised", 32'(par_err), 1);

    // R9 / R10: pointer reset with a pending half and a write in the same cycle
    tick();
    wr1(mk(8'h91, 8'h92, 0));
    wr1(mk(8'h93, 8'h94, 0));
    rd1("R9 before reset");
    ptr_rst = 1'b1; wr_en = 1'b1; wr_word = mk(8'hAB, 8'hCD, 0);
    tick();
    ptr_rst = 1'b0; wr_en = 1'b0;
    wq.delete(); mhalf = 0;
    @(negedge clk);
    chk("R9 empty", 32'(empty), 1);
    chk("R9 not full", 32'(full), 0);
    chk("R5 error survives ptr_rst", 32'(par_err), 1);
    tick();
    wr1(mk(8'h77, 8'h78, 0));
    rd1("R9 fresh word first");
    rd1("R9 fresh word upper");
    @(negedge clk);
    chk("R10 write during ptr_rst ignored", 32'(empty), 1);

    // R5 / R1: reset clears the error
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    mperr = 0;
    @(negedge clk);
    chk("R5 cleared by rst", 32'(par_err), 0);
    chk("R1 lane after rst", 32'(rd_lane), 0);

    repeat (3) tick();
    chk("R3 scoreboard drained", 32'(exp_q.size()), 0);
    finish_up();
  end

endmodule